// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit packed-integer execution unit. Each operand is split into lanes of 8, 16 or 32 bits, chosen per operation by a lane-width code. One operation is applied to every lane at once. The operations are add and subtract with selectable wrap, signed saturation or unsigned saturation; per-lane shifts; bitwise logic; compares that produce lane masks; and signed 16-bit multiply and multiply-add.

Operations enter through a valid/ready handshake and results leave through another one. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is held in one output register and is presented with `out_valid` from the next cycle on. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). A result that is not taken stays unchanged, and new operations are refused until it is taken. The unit computes the result in a single cycle, and the output register is the only state.

Top module: `simd_alu`

## Requirements
- R1: With `in_sat` 0 or 3 (wrap), opcode 0 (add) and opcode 1 (subtract) work modulo 2^W in each lane. `in_width` 0/1/2 selects W = 8/16/32. No carry or borrow passes between lanes.
- R2: With `in_sat` = 1, add and subtract treat lanes as signed and clamp an overflowing lane to 2^(W-1)-1 or -2^(W-1).
- R3: With `in_sat` = 2, add and subtract treat lanes as unsigned. An add that carries out gives all ones. A subtract that would go negative gives 0.
- R4: Opcodes 2/3/4 shift each lane of `in_a` left logical, right logical or right arithmetic. The count for each lane is the matching lane of `in_b`, read as unsigned.
- R5: A shift count of W or more gives 0 for the logical shifts and gives a lane filled with its sign bit for the arithmetic shift.
- R6: Opcodes 5/6/7/8 give a AND b, (NOT a) AND b, a OR b and a XOR b.
- R7: Opcode 9 (equal) and opcode 10 (signed greater-than, a > b) set each lane to all ones when the condition is true and to all zeros when it is false.
- R8: Opcode 11 forms four signed 16x16 products and returns the low 16 bits of each in its own lane. `in_width` and `in_sat` are ignored.
- R9: Opcode 12 multiplies the signed 16-bit lanes and adds products 0+1 and 2+3. The two sums go into 32-bit lanes 0 and 1, modulo 2^32. `in_width` and `in_sat` are ignored.
- R10: An accepted operation's result appears on `out_result` with `out_valid` high in the cycle after acceptance. `out_valid` rises only after an acceptance.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_result` holds its value.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.
- R13: Opcodes 13 to 15 give 0. Any opcode other than 11 and 12 with `in_width` = 3 also gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand or per-lane shift counts |
| in_op | input | 4 | Opcode |
| in_width | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=reserved |
| in_sat | input | 2 | Saturation: 0/3 wrap, 1 signed, 2 unsigned |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Packed result |

## Verification
Every operation has the same one-cycle latency. Its result is due in the cycle that follows the accepting edge, whatever the opcode, width or saturation mode. The bench drives each operation on a falling edge and lets it be accepted on the next rising edge. It then compares `out_result` and `out_valid` with a bench model on the falling edge after that. During back-pressure runs, the bench checks on every falling edge of the stall that the held value and `in_ready` do not change. It then checks that `out_valid` drops on the first edge that drains the result.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_SRA  = 4'd4,
    OP_AND  = 4'd5,
    OP_ANDN = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CEQ  = 4'd9,
    OP_CGT  = 4'd10,
    OP_MUL  = 4'd11,
    OP_MADD = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_16  = 2'd1,
    LW_32  = 2'd2,
    LW_RSV = 2'd3
  } lw_e;

  typedef enum logic [1:0] {
    SM_WRAP   = 2'd0,
    SM_SIGNED = 2'd1,
    SM_UNSIGN = 2'd2,
    SM_WRAP2  = 2'd3
  } sm_e;

  localparam int NUM_WIDTHS = 3;
endpackage

// File: rtl/simd_lane_part.sv
module simd_lane_part
  import simd_pkg::*;
#(
  parameter int DW = 64,
  parameter int W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  sm_e           sat,
  output wire  [DW-1:0] add_o,
  output wire  [DW-1:0] sub_o,
  output wire  [DW-1:0] sll_o,
  output wire  [DW-1:0] srl_o,
  output wire  [DW-1:0] sra_o,
  output wire  [DW-1:0] eq_o,
  output wire  [DW-1:0] gt_o
);
  localparam int NL = DW / W;
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [W-1:0] la, lb;
    logic [W:0]   s, d;
    logic         sov, dov, big;
    logic [SW-1:0] sh;
    logic [W-1:0] add_l, sub_l;

    assign la  = a[i*W +: W];
    assign lb  = b[i*W +: W];
    assign s   = {1'b0, la} + {1'b0, lb};
    assign d   = {1'b0, la} - {1'b0, lb};
    assign sov = (la[W-1] == lb[W-1]) && (s[W-1] != la[W-1]);
    assign dov = (la[W-1] != lb[W-1]) && (d[W-1] != la[W-1]);
    assign big = |lb[W-1:SW];
    assign sh  = lb[SW-1:0];

    always_comb begin
      case (sat)
        SM_SIGNED: begin
          add_l = sov ? (la[W-1] ? SMIN : SMAX) : s[W-1:0];
          sub_l = dov ? (la[W-1] ? SMIN : SMAX) : d[W-1:0];
        end
        SM_UNSIGN: begin
          add_l = s[W] ? {W{1'b1}} : s[W-1:0];
          sub_l = d[W] ? {W{1'b0}} : d[W-1:0];
        end
        default: begin
          add_l = s[W-1:0];
          sub_l = d[W-1:0];
        end
      endcase
    end

    assign add_o[i*W +: W] = add_l;
    assign sub_o[i*W +: W] = sub_l;
    assign sll_o[i*W +: W] = big ? {W{1'b0}} : (la << sh);
    assign srl_o[i*W +: W] = big ? {W{1'b0}} : (la >> sh);
    assign sra_o[i*W +: W] = big ? {W{la[W-1]}} : W'($signed(la) >>> sh);
    assign eq_o[i*W +: W]  = {W{la == lb}};
    assign gt_o[i*W +: W]  = {W{$signed(la) > $signed(lb)}};
  end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
  parameter int DW = 64,
  parameter int MW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output wire  [DW-1:0] mul_o,
  output wire  [DW-1:0] madd_o
);
  localparam int NM = DW / MW;
  localparam int PW = 2 * MW;
  localparam int NP = NM / 2;

  logic [PW-1:0] prod [NM];

  for (genvar j = 0; j < NM; j++) begin : g_prod
    assign prod[j] = PW'($signed(a[j*MW +: MW]) * $signed(b[j*MW +: MW]));
    assign mul_o[j*MW +: MW] = prod[j][MW-1:0];
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign madd_o[k*PW +: PW] = prod[2*k] + prod[2*k+1];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [3:0]    in_op,
  input  logic [1:0]    in_width,
  input  logic [1:0]    in_sat,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result
);
  wire [DW-1:0] add_v [NUM_WIDTHS];
  wire [DW-1:0] sub_v [NUM_WIDTHS];
  wire [DW-1:0] sll_v [NUM_WIDTHS];
  wire [DW-1:0] srl_v [NUM_WIDTHS];
  wire [DW-1:0] sra_v [NUM_WIDTHS];
  wire [DW-1:0] eq_v  [NUM_WIDTHS];
  wire [DW-1:0] gt_v  [NUM_WIDTHS];
  wire [DW-1:0] mul_r, madd_r;

  sm_e sat_m;
  lw_e lw;
  op_e op;
  assign sat_m = sm_e'(in_sat);
  assign lw    = lw_e'(in_width);
  assign op    = op_e'(in_op);

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_part
    simd_lane_part #(.DW(DW), .W(8 << g)) u_part (
      .a(in_a), .b(in_b), .sat(sat_m),
      .add_o(add_v[g]), .sub_o(sub_v[g]), .sll_o(sll_v[g]),
      .srl_o(srl_v[g]), .sra_o(sra_v[g]), .eq_o(eq_v[g]), .gt_o(gt_v[g])
    );
  end

  simd_mul16 #(.DW(DW), .MW(16)) u_mul (
    .a(in_a), .b(in_b), .mul_o(mul_r), .madd_o(madd_r)
  );

  logic [1:0]    wi;
  logic [DW-1:0] res_d;
  assign wi = in_width;

  always_comb begin
    res_d = '0;
    if (op == OP_MUL) begin
      res_d = mul_r;
    end else if (op == OP_MADD) begin
      res_d = madd_r;
    end else if (lw != LW_RSV) begin
      case (op)
        OP_ADD:  res_d = add_v[wi];
        OP_SUB:  res_d = sub_v[wi];
        OP_SLL:  res_d = sll_v[wi];
        OP_SRL:  res_d = srl_v[wi];
        OP_SRA:  res_d = sra_v[wi];
        OP_AND:  res_d = in_a & in_b;
        OP_ANDN: res_d = ~in_a & in_b;
        OP_OR:   res_d = in_a | in_b;
        OP_XOR:  res_d = in_a ^ in_b;
        OP_CEQ:  res_d = eq_v[wi];
        OP_CGT:  res_d = gt_v[wi];
        default: res_d = '0;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (in_valid && in_ready) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_op,
  input logic [1:0]    in_width,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result
);
  logic       cmp_q;
  logic [1:0] cw_q;
  logic       mask_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      cw_q  <= 2'd0;
    end else if (in_valid && in_ready) begin
      cmp_q <= (in_op == 4'd9) || (in_op == 4'd10);
      cw_q  <= in_width;
    end
  end

  always_comb begin
    mask_ok = 1'b1;
    for (int k = 0; k < DW/8; k++)
      if (cw_q == 2'd0 && !(out_result[k*8 +: 8] == '0 || out_result[k*8 +: 8] == '1)) mask_ok = 1'b0;
    for (int k = 0; k < DW/16; k++)
      if (cw_q == 2'd1 && !(out_result[k*16 +: 16] == '0 || out_result[k*16 +: 16] == '1)) mask_ok = 1'b0;
    for (int k = 0; k < DW/32; k++)
      if (cw_q == 2'd2 && !(out_result[k*32 +: 32] == '0 || out_result[k*32 +: 32] == '1)) mask_ok = 1'b0;
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R11
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11
  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R10
  AST_CMP_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cmp_q) |-> mask_ok); // R7
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_width(in_width), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_width = '0, in_sat = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_width(in_width),
    .in_sat(in_sat), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  function automatic logic [63:0] ref_model(logic [63:0] a, logic [63:0] b,
                                            int op, int w, int sat);
    logic [63:0] r;
    longint m, ua, ub, sa, sb, t, lo, hi;
    int W;
    r = '0;
    if (op == 11 || op == 12) begin
      longint p [4];
      for (int j = 0; j < 4; j++) begin
        sa = longint'($signed(a[j*16 +: 16]));
        sb = longint'($signed(b[j*16 +: 16]));
        p[j] = sa * sb;
        if (op == 11) r[j*16 +: 16] = p[j][15:0];
      end
      if (op == 12) begin
        t = p[0] + p[1]; r[31:0]  = t[31:0];
        t = p[2] + p[3]; r[63:32] = t[31:0];
      end
      return r;
    end
    if (w == 3 || op > 12) return '0;
    W = 8 << w;
    m = (longint'(1) << W) - 1;
    lo = -(longint'(1) << (W-1));
    hi = (longint'(1) << (W-1)) - 1;
    for (int i = 0; i < 64 / W; i++) begin
      ua = longint'(a >> (i*W)) & m;
      ub = longint'(b >> (i*W)) & m;
      sa = ((ua >> (W-1)) & 1) != 0 ? ua - (m + 1) : ua;
      sb = ((ub >> (W-1)) & 1) != 0 ? ub - (m + 1) : ub;
      case (op)
        0, 1: begin
          if (sat == 1) begin
            t = (op == 0) ? sa + sb : sa - sb;
            if (t > hi) t = hi;
            if (t < lo) t = lo;
          end else begin
            t = (op == 0) ? ua + ub : ua - ub;
            if (sat == 2 && t > m) t = m;
            if (sat == 2 && t < 0) t = 0;
          end
        end
        2: t = (ub >= W) ? 0 : (ua << ub);
        3: t = (ub >= W) ? 0 : (ua >> ub);
        4: t = sa >>> ((ub >= W) ? (W-1) : ub);
        5: t = ua & ub;
        6: t = ~ua & ub;
        7: t = ua | ub;
        8: t = ua ^ ub;
        9: t = (ua == ub) ? m : 0;
        default: t = (sa > sb) ? m : 0;
      endcase
      t = t & m;
      r = r | (64'(t) << (i*W));
    end
    return r;
  endfunction

  function automatic string tag_of(int op, int w, int sat);
    if (op > 12 || (w == 3 && op < 11)) return "R13";
    if (op <= 1) return (sat == 1) ? "R2" : (sat == 2) ? "R3" : "R1";
    if (op <= 4) return "R4";
    if (op <= 8) return "R6";
    if (op <= 10) return "R7";
    if (op == 11) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, int op, int w, int sat, string req);
    logic [63:0] e;
    e = ref_model(a, b, op, w, sat);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op[3:0]; in_width = w[1:0]; in_sat = sat[1:0];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {63'd0, out_valid}, 64'd1);
    check(req, out_result, e);
  endtask

  function automatic logic [63:0] corner(int k);
    case (k % 6)
      0: return 64'h8000_0000_8000_0000;
      1: return 64'h7FFF_FFFF_7FFF_FFFF;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8080_8080_8080_8080;
      4: return 64'h7F7F_7F7F_7F7F_7F7F;
      default: return 64'h0000_0000_0000_0001;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] held, e1;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;

    // R1 wrap, no carry across lanes
    send(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0, 0, "R1");
    send(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 1, 0, "R1");
    send(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1, 2, 3, "R1");
    // R2 signed clamp
    send(64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF, 0, 0, 1, "R2");
    send(64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_0001_FFFF, 1, 1, 1, "R2");
    // R3 unsigned clamp
    send(64'hFFFF_FFF0_0000_0005, 64'h0000_0020_0000_0009, 0, 2, 2, "R3");
    send(64'h0102_0304_0506_0708, 64'h0203_0304_0405_0809, 1, 0, 2, "R3");
    // R4 in-range shifts
    send(64'h8181_8181_8181_8181, 64'h0001_0203_0405_0607, 2, 0, 0, "R4");
    send(64'h8000_1234_8000_1234, 64'h0004_0004_000F_0001, 4, 1, 0, "R4");
    // R5 count >= width
    send(64'h8000_0000_7000_0000, 64'h0000_0020_0000_0040, 4, 2, 0, "R5");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0810_FF08_0810_FF08, 2, 0, 0, "R5");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0010_1000_0011_FFFF, 3, 1, 0, "R5");
    // R6 logic
    send(64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 6, 2, 0, "R6");
    // R7 compares
    send(64'h0102_0304_8000_0001, 64'h0102_0305_7FFF_0001, 9, 1, 0, "R7");
    send(64'h0180_7F00_0000_0001, 64'h0001_8000_FFFF_FFFF, 10, 0, 0, "R7");
    // R8 / R9 multiply, width ignored
    send(64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFB, 11, 3, 1, "R8");
    send(64'h8000_8000_7FFF_0002, 64'h8000_8000_7FFF_0003, 12, 0, 2, "R9");
    // R13 unused codes
    send(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 13, 0, 0, "R13");
    send(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0, 3, 0, "R13");

    // R11 back-pressure: result held, second offer refused
    e1 = ref_model(64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 64'h0102_0304_0506_0708; in_b = 64'h1010_1010_1010_1010;
    in_op = 4'd0; in_width = 2'd0; in_sat = 2'd0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 64'hDEAD_BEEF_DEAD_BEEF; in_op = 4'd8;
    held = out_result;
    check("R11", held, e1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R11", {62'd0, out_valid, in_ready}, 64'd2);
      check("R11", out_result, e1);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      int op, w, sat;
      op  = $urandom_range(0, 15);
      w   = $urandom_range(0, 3);
      sat = $urandom_range(0, 3);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a = corner($urandom_range(0, 5));
      if ($urandom_range(0, 3) == 0) b = corner($urandom_range(0, 5));
      if (op >= 2 && op <= 4 && $urandom_range(0, 1) == 1) b = b & 64'h0707_0707_0707_0707;
      send(a, b, op, w, sat, tag_of(op, w, sat));
    end

    finish_run();
  end
endmodule